// File: doc/BRIEF.md
# Serial Controller Register Front End

This block is the register side of a serial controller. A processor reaches it through a simple word-addressed register bus, and the rest of the chip connects through two byte streams: incoming characters arrive on a receive port and outgoing characters leave on a transmit port. Bit-level framing, baud generation, parity, flow control and DMA all sit elsewhere. The baud-rate, control and guard-time registers are stored here so that the serialiser can read them, but they have no effect inside this block. The one exception is the first control register, whose enable bits gate reception and the receive interrupt.

Three status flags describe the data path: receive-not-empty, transmit-complete and transmit-empty. Register accesses have side effects on these flags. An incoming byte is taken only while no unread byte is held, so the receive port has back-pressure. A byte is kept only when the controller and its receiver are both enabled. The interrupt output is a level that follows receive-not-empty gated by its enable bit.

Top module: `usart_front`

## Requirements
- R1: After reset the status register reads 0x000000C0 (transmit-empty at bit 7 and transmit-complete at bit 6 set, receive-not-empty at bit 5 clear), every other register reads zero, the interrupt is low and no transmit byte is offered.
- R2: Registers sit at byte offsets status 0x00, data 0x04, baud 0x08, control-A 0x0C, control-B 0x10, control-C 0x14 and guard/prescale 0x18. The five registers from 0x08 upward return the last full 32-bit word written to them. Any other offset reads zero, and a write to it changes nothing.
- R3: A byte offered on the receive port while receive-not-empty is clear is consumed. It is stored and sets receive-not-empty only if control-A bit 13 (controller enable) and bit 2 (receiver enable) are both set. Otherwise it is discarded, and both the flags and the data register are left unchanged.
- R4: The receive ready output is high exactly when receive-not-empty is clear.
- R5: A data-register read returns the held receive byte zero-extended into the low 10 bits and clears receive-not-empty. It also sets transmit-empty when no transmit byte is pending.
- R6: A status read returns the flags as they stood before the access, and transmit-complete is clear from the next cycle.
- R7: A data-register write made while no transmit byte is pending offers its low 8 bits on the transmit port, sets transmit-complete and clears transmit-empty. The byte stays offered and unchanged until the transmit ready is high. A data write made while a byte is pending is ignored.
- R8: Transmit-empty stays clear while a byte is pending and becomes set in the cycle after the transmit port accepts it.
- R9: A status write clears each flag whose bit is written as 0 and leaves each flag whose bit is written as 1 unchanged. It never sets a flag.
- R10: The interrupt equals receive-not-empty AND control-A bit 5, with no register delay. Setting the enable while the flag is already set raises the interrupt in the same cycle that the new enable value appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid in the cycle of a read |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing byte offered |
| tx_byte | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Consumer takes the outgoing byte |
| irq | output | 1 | Receive interrupt level |

## Verification
The bench targets bytes that arrive while the controller, the receiver or both are disabled. A design that drops them wrongly would still raise receive-not-empty or overwrite the held byte. A second data write made while the first byte is still waiting must be ignored; a design that gets this wrong replaces or duplicates the outgoing byte. A status read must report transmit-complete before clearing it, so a design that clears it first reads back a zero. Status writes of all ones must leave the flags as they are; a design that lets them set flags would show a phantom receive-not-empty. Enabling the interrupt while a byte is already held must raise the line at once, and a design that waits for a new byte stays silent. Long random runs with random back-pressure on both streams catch priority errors where a hardware set and a software clear meet in the same cycle.

// File: rtl/usart_front_pkg.sv
// Package: shared offsets, bit positions and the access-decode struct for
// the serial controller register front end.
package usart_front_pkg;

    // Register offsets that software depends on
    localparam int OFF_STATUS     = 'h00;
    localparam int OFF_DATA       = 'h04;
    localparam int OFF_PLAIN_BASE = 'h08;   // first of the storage-only registers
    localparam int N_PLAIN        = 5;      // baud, ctl A/B/C, guard/prescale
    localparam int CTL_A_INDEX    = 1;      // control-A is the second storage register

    // Status flag positions
    localparam int FLAG_RXNE = 5;
    localparam int FLAG_TC   = 6;
    localparam int FLAG_TXE  = 7;

    // Control-A bit positions
    localparam int CTL_RX_EN   = 2;
    localparam int CTL_TX_EN   = 3;
    localparam int CTL_RX_IE   = 5;
    localparam int CTL_MAIN_EN = 13;

    // Width of the data-register read field
    localparam int DATA_READ_W = 10;

    // Decoded side-effect strobes for the flag logic
    typedef struct packed {
        logic rd_status;
        logic wr_status;
        logic rd_data;
        logic wr_data;
    } flag_access_t;

endpackage

// File: rtl/usart_plain_regs.sv
// Module: usart_plain_regs
// Bank of storage-only registers. Each register loads the full write word on
// its own strobe and is otherwise held.
// Assumes: at most one strobe is active per cycle (the decoder guarantees it).
module usart_plain_regs #(
    parameter int REG_W  = 32,
    parameter int N_REGS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_REGS-1:0]     wr_en,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      q [N_REGS]
);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        logic [REG_W-1:0] r;

        // Purpose: hold one register, cleared by reset, loaded on its strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en[i]) begin
                r <= wdata;
            end
        end

        assign q[i] = r;
    end

endmodule

// File: rtl/usart_tx_hold.sv
// Module: usart_tx_hold
// One-entry holding stage for the outgoing byte. A load is taken only when
// the stage is empty; the byte is offered with valid until the consumer
// raises ready.
// Assumes: load is a single-cycle strobe from the data-register write decode.
module usart_tx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              taken,      // load accepted this cycle
    output logic              done,       // consumer handshake this cycle
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_ready
);

    assign taken = load && !tx_valid;
    assign done  = tx_valid && tx_ready;

    // Purpose: fill on an accepted load, empty on a handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else if (taken) begin
            tx_valid <= 1'b1;
            tx_byte  <= load_byte;
        end else if (done) begin
            tx_valid <= 1'b0;
        end
    end

    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

endmodule

// File: rtl/usart_status_flags.sv
// Module: usart_status_flags
// Owns the three status flags and the received-byte register. Register access
// side effects clear flags and hardware events set them; when both happen in
// one cycle the set wins.
// Assumes: the access strobes are mutually exclusive, and tx_taken / tx_done
// come from the transmit holding stage and never occur together.
module usart_status_flags #(
    parameter int BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  usart_front_pkg::flag_access_t acc,
    input  logic                          keep_rxne,   // status write bit for RXNE
    input  logic                          keep_tc,
    input  logic                          keep_txe,
    input  logic                          tx_taken,
    input  logic                          tx_pending,
    input  logic                          tx_done,
    input  logic                          rx_enabled,
    input  logic                          rx_valid,
    input  logic [BYTE_W-1:0]             rx_byte,
    output logic                          rx_ready,
    output logic                          rxne_q,
    output logic                          tc_q,
    output logic                          txe_q,
    output logic [BYTE_W-1:0]             rx_data_q
);

    logic rx_fire, rx_take;
    logic rxne_clr, tc_clr, txe_clr, txe_set;

    assign rx_ready = !rxne_q;
    assign rx_fire  = rx_valid && rx_ready;
    assign rx_take  = rx_fire && rx_enabled;

    // Purpose: collect the clearing and setting conditions for each flag
    always_comb begin
        rxne_clr = acc.rd_data   || (acc.wr_status && !keep_rxne);
        tc_clr   = acc.rd_status || (acc.wr_status && !keep_tc);
        txe_clr  = tx_taken      || (acc.wr_status && !keep_txe);
        txe_set  = tx_done       || (acc.rd_data && !tx_pending);
    end

    // Purpose: update flags (set beats clear) and capture enabled receive bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxne_q    <= 1'b0;
            tc_q      <= 1'b1;
            txe_q     <= 1'b1;
            rx_data_q <= '0;
        end else begin
            rxne_q <= (rxne_q && !rxne_clr) || rx_take;
            tc_q   <= (tc_q   && !tc_clr)   || tx_taken;
            txe_q  <= (txe_q  && !txe_clr)  || txe_set;
            if (rx_take) begin
                rx_data_q <= rx_byte;
            end
        end
    end

    assert_rx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !rx_enabled) |=> (!rxne_q && $stable(rx_data_q)));

    assert_rx_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_enabled) |=> (rxne_q && rx_data_q == $past(rx_byte)));

    assert_tc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc.rd_status |=> !tc_q);

    assert_status_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.wr_status && !(rx_valid && rx_ready && rx_enabled))
            |=> !(rxne_q && !$past(rxne_q)));

endmodule

// File: rtl/usart_front.sv
// Module: usart_front (top)
// Register front end of a serial controller: decodes the register bus, stores
// the configuration words, drives the flag side effects, the receive
// back-pressure, the transmit holding stage and the receive interrupt.
// Assumes: one bus access per cycle; read data is consumed in the same cycle.
module usart_front #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_ready,
    output logic              irq
);
    import usart_front_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);

    logic              rd_cyc, wr_cyc;
    logic              hit_status, hit_data;
    flag_access_t      acc;
    logic [N_PLAIN-1:0] plain_we;
    logic [DATA_W-1:0] plain_q [N_PLAIN];
    logic [DATA_W-1:0] ctl_a;
    logic              tx_taken, tx_done;
    logic              rxne, tc, txe;
    logic [BYTE_W-1:0] rx_data;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] data_word;

    assign rd_cyc     = bus_en && !bus_we;
    assign wr_cyc     = bus_en &&  bus_we;
    assign hit_status = (bus_addr == A_STATUS);
    assign hit_data   = (bus_addr == A_DATA);

    // Purpose: form the flag side-effect strobes from the access
    always_comb begin
        acc.rd_status = rd_cyc && hit_status;
        acc.wr_status = wr_cyc && hit_status;
        acc.rd_data   = rd_cyc && hit_data;
        acc.wr_data   = wr_cyc && hit_data;
    end

    for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain_we
        assign plain_we[i] = wr_cyc && (bus_addr == ADDR_W'(OFF_PLAIN_BASE + 4 * i));
    end

    usart_plain_regs #(
        .REG_W  (DATA_W),
        .N_REGS (N_PLAIN)
    ) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (plain_we),
        .wdata (bus_wdata),
        .q     (plain_q)
    );

    assign ctl_a = plain_q[CTL_A_INDEX];

    usart_tx_hold #(
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc.wr_data),
        .load_byte (bus_wdata[BYTE_W-1:0]),
        .taken     (tx_taken),
        .done      (tx_done),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_ready  (tx_ready)
    );

    usart_status_flags #(
        .BYTE_W (BYTE_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .keep_rxne  (bus_wdata[FLAG_RXNE]),
        .keep_tc    (bus_wdata[FLAG_TC]),
        .keep_txe   (bus_wdata[FLAG_TXE]),
        .tx_taken   (tx_taken),
        .tx_pending (tx_valid),
        .tx_done    (tx_done),
        .rx_enabled (ctl_a[CTL_MAIN_EN] && ctl_a[CTL_RX_EN]),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .rx_ready   (rx_ready),
        .rxne_q     (rxne),
        .tc_q       (tc),
        .txe_q      (txe),
        .rx_data_q  (rx_data)
    );

    // Purpose: assemble the status and data read words
    always_comb begin
        status_word            = '0;
        status_word[FLAG_RXNE] = rxne;
        status_word[FLAG_TC]   = tc;
        status_word[FLAG_TXE]  = txe;
        data_word              = '0;
        data_word[DATA_READ_W-1:0] = DATA_READ_W'(rx_data);
    end

    // Purpose: read multiplexer; unmapped offsets and idle cycles give zero
    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            if (hit_status) begin
                bus_rdata = status_word;
            end else if (hit_data) begin
                bus_rdata = data_word;
            end else begin
                for (int i = 0; i < N_PLAIN; i++) begin
                    if (bus_addr == ADDR_W'(OFF_PLAIN_BASE + 4 * i)) begin
                        bus_rdata = plain_q[i];
                    end
                end
            end
        end
    end

    // Purpose: receive interrupt level, no register stage
    assign irq = rxne && ctl_a[CTL_RX_IE];

    assert_txe_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !txe);

    assert_tc_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |=> (tc && tx_valid));

endmodule

// File: tb/usart_front_bench.sv
// Bench for usart_front: directed corner cases, then seeded random traffic,
// all compared against a cycle model kept in bench variables.
module usart_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic        irq;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    bit          done   = 1'b0;

    // model state
    bit        m_rxne, m_tc, m_txe, m_pend;
    bit [7:0]  m_dr, m_tbyte;
    bit [31:0] m_plain [5];

    always #5 clk = ~clk;

    usart_front u_usart_front (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .irq(irq)
    );

    function automatic bit [31:0] model_read(input bit [7:0] a);
        bit [31:0] v = '0;
        if (a == 8'h00) begin
            v[5] = m_rxne; v[6] = m_tc; v[7] = m_txe;
        end else if (a == 8'h04) begin
            v = {24'h0, m_dr};
        end else if (a >= 8'h08 && a <= 8'h18 && a[1:0] == 2'b00) begin
            v = m_plain[(a - 8'h08) >> 2];
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rxne = 0; m_tc = 1; m_txe = 1; m_pend = 0; m_dr = 0; m_tbyte = 0;
        for (int i = 0; i < 5; i++) m_plain[i] = '0;
    endtask

    // Apply one cycle of stimulus, check outputs, then advance the model.
    task automatic cycle(input bit en, input bit we, input bit [7:0] a, input bit [31:0] wd,
                         input bit rv, input bit [7:0] rb, input bit tr, input string tag);
        bit [31:0] exp_rd;
        bit rxne_n, tc_n, txe_n, take, acc_tx;
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_byte = rb; tx_ready = tr;
        #1;
        exp_rd = (en && !we) ? model_read(a) : 32'h0;
        check(bus_rdata == exp_rd, tag, bus_rdata, exp_rd);
        check(irq == (m_rxne && m_plain[1][5]), "R10 irq", {31'h0, irq}, {31'h0, m_rxne && m_plain[1][5]});
        check(rx_ready == !m_rxne, "R4 rx_ready", {31'h0, rx_ready}, {31'h0, !m_rxne});
        check(tx_valid == m_pend && (!m_pend || tx_byte == m_tbyte), "R7 tx port",
              {23'h0, tx_valid, tx_byte}, {23'h0, m_pend, m_tbyte});
        @(posedge clk);
        rxne_n = m_rxne; tc_n = m_tc; txe_n = m_txe;
        take   = rv && !m_rxne && m_plain[1][13] && m_plain[1][2];
        acc_tx = m_pend && tr;
        if (en && !we && a == 8'h00) tc_n = 0;
        if (en && !we && a == 8'h04) begin rxne_n = 0; if (!m_pend) txe_n = 1; end
        if (en && we && a == 8'h00) begin
            rxne_n = rxne_n & wd[5]; tc_n = tc_n & wd[6]; txe_n = txe_n & wd[7];
        end
        if (en && we && a == 8'h04 && !m_pend) begin
            tc_n = 1; txe_n = 0; m_pend = 1; m_tbyte = wd[7:0];
        end else if (acc_tx) begin
            m_pend = 0; txe_n = 1;
        end
        if (take) begin rxne_n = 1; m_dr = rb; end
        if (en && we && a >= 8'h08 && a <= 8'h18 && a[1:0] == 2'b00)
            m_plain[(a - 8'h08) >> 2] = wd;
        m_rxne = rxne_n; m_tc = tc_n; m_txe = txe_n;
    endtask

    task automatic rd(input bit [7:0] a, input string tag);
        cycle(1, 0, a, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        cycle(1, 1, a, d, 0, 0, 0, tag);
    endtask

    function automatic bit [7:0] pick_addr();
        case ($urandom % 9)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;
            3: return 8'h0C;  4: return 8'h10;  5: return 8'h14;
            6: return 8'h18;  7: return 8'h1C;  default: return 8'h40;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        bit [31:0] seed_sink;
        seed_sink = $urandom(32'd20250611);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        rd(8'h00, "R1 status after reset");
        for (int i = 0; i < 6; i++) rd(8'h04 + 8'(4 * i), "R1 register after reset");

        // R2: storage registers read back; unmapped offset ignored
        for (int i = 0; i < 5; i++) wr(8'h08 + 8'(4 * i), 32'hA5000000 | 32'(i), "R2 write");
        for (int i = 0; i < 5; i++) rd(8'h08 + 8'(4 * i), "R2 readback");
        wr(8'h1C, 32'hFFFFFFFF, "R2 unmapped write");
        rd(8'h1C, "R2 unmapped read");

        // R3: byte dropped when only the receiver is enabled
        wr(8'h0C, 32'h0000_0004, "R3 ctl");
        cycle(0, 0, 0, 0, 1, 8'h5A, 0, "R3 drop idle");
        rd(8'h00, "R3 status after dropped byte");
        // R3: byte dropped when only the main enable is set
        wr(8'h0C, 32'h0000_2000, "R3 ctl");
        cycle(0, 0, 0, 0, 1, 8'h6B, 0, "R3 drop idle");
        rd(8'h04, "R3 data unchanged after drop");
        // R3: byte kept with both enables
        wr(8'h0C, 32'h0000_2004, "R3 ctl");
        cycle(0, 0, 0, 0, 1, 8'hA5, 0, "R3 take idle");
        rd(8'h00, "R3 status after taken byte");

        // R4 back-pressure, R10 immediate interrupt on late enable
        cycle(0, 0, 0, 0, 1, 8'h11, 0, "R4 offered while full");
        wr(8'h0C, 32'h0000_2024, "R10 enable irq");
        cycle(0, 0, 0, 0, 0, 0, 0, "R10 irq level");
        // R5: data read returns held byte, clears flag
        rd(8'h04, "R5 data read");
        rd(8'h00, "R5 status after data read");

        // R7/R8: write held, second write ignored, accept sets TXE
        wr(8'h04, 32'h0000_013C, "R7 data write");
        rd(8'h00, "R8 status while pending");
        wr(8'h04, 32'h0000_0077, "R7 write while pending");
        cycle(0, 0, 0, 0, 0, 0, 1, "R7 accept");
        rd(8'h00, "R8 status after accept");

        // R9: status write of ones keeps flags, zeros clear them
        cycle(0, 0, 0, 0, 1, 8'h42, 0, "R9 load rx");
        wr(8'h00, 32'hFFFFFFFF, "R9 write ones");
        rd(8'h00, "R9 status after ones");
        wr(8'h00, 32'h0000_0000, "R9 write zeros");
        rd(8'h00, "R9 status after zeros");
        wr(8'h00, 32'h0000_00E0, "R9 no set");
        rd(8'h00, "R9 status cannot be set");

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            bit        en, we;
            bit [7:0]  a;
            bit [31:0] wd;
            string     tag;
            en = ($urandom % 3) != 0;
            we = $urandom % 2;
            a  = pick_addr();
            wd = $urandom;
            if (a == 8'h0C && ($urandom % 4) != 0) wd = wd | 32'h0000_2004;
            if (a == 8'h00 && ($urandom % 2) != 0) wd = wd | 32'h0000_00E0;
            if (a == 8'h00)      tag = "R6 status read";
            else if (a == 8'h04) tag = "R5 data read";
            else                 tag = "R2 register read";
            cycle(en, we, a, wd, $urandom % 2, 8'($urandom), ($urandom % 3) == 0, tag);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule